// File: doc/BRIEF.md
# Platform Power Request Register Block

This block is a small slave on a simple 32-bit register bus. It lets software find out that the platform offers power control, and lets it ask the platform to restart, stop, or stop with a panic indication. It occupies a 256-byte window and has two registers in it. The capability register is read-only and always reports power control support. The command register is write-only. Each valid code written to it produces a single-cycle request on one of three dedicated outputs. The logic that acts on those requests sits outside this block.

Every bus access completes in the cycle it is presented: `bus_ready` follows `bus_sel` combinationally. Read data is registered. It appears in the cycle after the accepted read and is held until the next accepted read. Request pulses are also registered. They appear in the cycle after the accepted write and last exactly one cycle.

Top module: `pwr_ctl_regs`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `bus_rdata` and all three request outputs are cleared to zero after that edge, even if a command write is presented in the same cycle.
- R2: `bus_ready` is high in exactly the cycles in which `bus_sel` is high, for reads and writes alike.
- R3: A read (`bus_sel`=1, `bus_we`=0) at byte offset 0x00 makes `bus_rdata` equal 0x00000001 (bit 0 = power control supported) in the following cycle, whatever the byte strobes.
- R4: A read at any other offset makes `bus_rdata` zero in the following cycle and raises no request. This covers the command offset 0x04, unaligned offsets, and any address with bits set above the 8-bit window offset.
- R5: A write of value 1 to offset 0x04 with all four strobes set raises `req_reset` for exactly one cycle, the cycle after the write.
- R6: A write of value 2 to offset 0x04 with all four strobes set raises `req_halt` for exactly one cycle, the cycle after the write.
- R7: A write of value 3 to offset 0x04 with all four strobes set raises `req_panic` for exactly one cycle, the cycle after the write.
- R8: A write of value 0 (no-op) to offset 0x04 completes its handshake and raises no request.
- R9: A write to offset 0x04 of any 32-bit value outside 0..3, including values with only upper bits set, raises no request.
- R10: Writes to any offset other than 0x04 raise no request and leave `bus_rdata` unchanged.
- R11: A write to offset 0x04 with any strobe pattern other than 4'b1111 raises no request.
- R12: At most one request output is high in any cycle. Back-to-back command writes produce pulses in back-to-back cycles.
- R13: `bus_rdata` holds its value in every cycle that follows a cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_be | input | DATA_W/8 (4) | Byte strobes for writes |
| bus_rdata | output | DATA_W (32) | Registered read data, valid the cycle after a read |
| bus_ready | output | 1 | Handshake, high in the same cycle as `bus_sel` |
| req_reset | output | 1 | One-cycle system restart request |
| req_halt | output | 1 | One-cycle shutdown request |
| req_panic | output | 1 | One-cycle shutdown-with-panic request |

## Verification
`bus_ready` is combinational, so the bench checks it a short delay after it drives an access, in the same cycle. Read data and request pulses each pass through one register. The bench drives each access just after a falling edge and samples those results at the next falling edge, which lies after the single capturing rising edge. For writes, the bench also samples one cycle later and expects all requests low there, so that a pulse wider than one cycle is caught. Reset and back-to-back cases use the same one-register count: a reset edge suppresses the pulse of a write seen at that edge, and two consecutive writes must give pulses on two consecutive sampling points.

// File: rtl/pwrc_pkg.sv
package pwrc_pkg;

  // Window and register layout: software depends on these offsets.
  localparam int unsigned WIN_BYTES = 256;
  localparam int unsigned CAP_OFF   = 0;
  localparam int unsigned CMD_OFF   = 4;

  // Capability word: bit 0 advertises power control.
  localparam logic [31:0] CAP_WORD = 32'h0000_0001;

  // Command codes accepted by the command register.
  typedef enum logic [1:0] {
    PC_NOP   = 2'd0,
    PC_RESET = 2'd1,
    PC_HALT  = 2'd2,
    PC_PANIC = 2'd3
  } pc_cmd_e;

  // One bit per outgoing request line.
  typedef struct packed {
    logic panic;
    logic halt;
    logic restart;
  } pc_req_t;

  // True when every strobe bit of a lane vector is set.
  function automatic logic all_lanes(input logic [3:0] be);
    return &be;
  endfunction

  // Map a legal code to its request vector; the no-op maps to none.
  function automatic pc_req_t code_to_req(input pc_cmd_e c);
    pc_req_t r;
    r = '0;
    unique case (c)
      PC_RESET: r.restart = 1'b1;
      PC_HALT:  r.halt    = 1'b1;
      PC_PANIC: r.panic   = 1'b1;
      default:  r         = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwrc_decode.sv
module pwrc_decode
  import pwrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BE_W   = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  output logic              bus_ready,
  output logic              rd_fire,
  output logic              rd_cap_hit,
  output logic              wr_cmd_hit
);

  localparam int unsigned OFF_W = $clog2(WIN_BYTES);

  logic              in_window;
  logic [OFF_W-1:0]  offset;
  logic              full_word;

  // Bits above the window offset must be zero for a hit.
  generate
    if (ADDR_W > OFF_W) begin : g_wide
      assign in_window = (bus_addr[ADDR_W-1:OFF_W] == '0);
      assign offset    = bus_addr[OFF_W-1:0];
    end else begin : g_exact
      assign in_window = 1'b1;
      assign offset    = OFF_W'(bus_addr);
    end
  endgenerate

  // Only a full 32-bit write is a legal command access.
  generate
    if (BE_W == 4) begin : g_be4
      assign full_word = all_lanes(bus_be);
    end else begin : g_bex
      assign full_word = &bus_be;
    end
  endgenerate

  assign bus_ready  = bus_sel;
  assign rd_fire    = bus_sel & ~bus_we;
  assign rd_cap_hit = rd_fire & in_window & (offset == OFF_W'(CAP_OFF));
  assign wr_cmd_hit = bus_sel & bus_we & in_window
                      & (offset == OFF_W'(CMD_OFF)) & full_word;

endmodule

// File: rtl/pwrc_cmd.sv
module pwrc_cmd
  import pwrc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              req_reset,
  output logic              req_halt,
  output logic              req_panic
);

  // A value is a legal code only if every bit above the code field is zero.
  function automatic logic code_in_range(input logic [DATA_W-1:0] v);
    return (v[DATA_W-1:2] == '0);
  endfunction

  logic    code_ok;
  pc_cmd_e code;
  pc_req_t fire;
  pc_req_t req_q;

  assign code_ok = code_in_range(wdata);
  assign code    = pc_cmd_e'(wdata[1:0]);
  assign fire    = (wr_cmd_hit && code_ok) ? code_to_req(code) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= fire;
  end

  assign req_reset = req_q.restart;
  assign req_halt  = req_q.halt;
  assign req_panic = req_q.panic;

  assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_reset, req_halt, req_panic}));

  assert_pulse_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_reset | req_halt | req_panic) |-> $past(wr_cmd_hit));

  assert_noop_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_hit && wdata == '0) |=> !(req_reset | req_halt | req_panic));

  assert_out_of_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_hit && !code_ok) |=> !(req_reset | req_halt | req_panic));

endmodule

// File: rtl/pwrc_rdata.sv
module pwrc_rdata
  import pwrc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              rd_cap_hit,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_next;

  assign rd_next = rd_cap_hit ? DATA_W'(CAP_WORD) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_fire) rdata <= rd_next;
  end

  assert_cap_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap_hit |=> (rdata == DATA_W'(CAP_WORD)));

  assert_other_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !rd_cap_hit) |=> (rdata == '0));

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rdata));

endmodule

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs
  import pwrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_ready,
  output logic                req_reset,
  output logic                req_halt,
  output logic                req_panic
);

  localparam int unsigned BE_W = DATA_W / 8;

  logic rd_fire;
  logic rd_cap_hit;
  logic wr_cmd_hit;

  pwrc_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_ready  (bus_ready),
    .rd_fire    (rd_fire),
    .rd_cap_hit (rd_cap_hit),
    .wr_cmd_hit (wr_cmd_hit)
  );

  pwrc_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd_hit (wr_cmd_hit),
    .wdata      (bus_wdata),
    .req_reset  (req_reset),
    .req_halt   (req_halt),
    .req_panic  (req_panic)
  );

  pwrc_rdata #(.DATA_W(DATA_W)) u_rdata (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (rd_fire),
    .rd_cap_hit (rd_cap_hit),
    .rdata      (bus_rdata)
  );

  // Port-level checks on write routing.
  assert_wrong_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr != ADDR_W'(CMD_OFF))
      |=> !(req_reset | req_halt | req_panic));

  assert_partial_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !(&bus_be)) |=> !(req_reset | req_halt | req_panic));

  assert_read_no_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> !(req_reset | req_halt | req_panic));

  assert_reset_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(CMD_OFF) && (&bus_be)
     && bus_wdata == DATA_W'(1)) |=> req_reset);

  assert_halt_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(CMD_OFF) && (&bus_be)
     && bus_wdata == DATA_W'(2)) |=> req_halt);

  assert_panic_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(CMD_OFF) && (&bus_be)
     && bus_wdata == DATA_W'(3)) |=> req_panic);

  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> bus_ready);

endmodule

// File: tb/pwr_ctl_regs_bench.sv
module pwr_ctl_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 17;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic [2:0]  exp_p;   // {panic, halt, reset}
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 4'hF, 32'h0,   32'h1, 3'b000, 4'd3},   // R3 capability read
    '{1'b1, 8'h04, 4'hF, 32'h1,   32'h1, 3'b001, 4'd5},   // R5 restart
    '{1'b1, 8'h04, 4'hF, 32'h2,   32'h1, 3'b010, 4'd6},   // R6 halt
    '{1'b1, 8'h04, 4'hF, 32'h3,   32'h1, 3'b100, 4'd7},   // R7 panic
    '{1'b1, 8'h04, 4'hF, 32'h0,   32'h1, 3'b000, 4'd8},   // R8 no-op
    '{1'b1, 8'h04, 4'hF, 32'h5,   32'h1, 3'b000, 4'd9},   // R9 out of range
    '{1'b1, 8'h04, 4'hF, 32'h101, 32'h1, 3'b000, 4'd9},   // R9 upper bits set
    '{1'b1, 8'h00, 4'hF, 32'h1,   32'h1, 3'b000, 4'd10},  // R10 write to capability
    '{1'b1, 8'h08, 4'hF, 32'h1,   32'h1, 3'b000, 4'd10},  // R10 unused offset
    '{1'b1, 8'h04, 4'h7, 32'h1,   32'h1, 3'b000, 4'd11},  // R11 three lanes
    '{1'b1, 8'h04, 4'h1, 32'h1,   32'h1, 3'b000, 4'd11},  // R11 one lane
    '{1'b0, 8'h04, 4'hF, 32'h0,   32'h0, 3'b000, 4'd4},   // R4 read of command offset
    '{1'b0, 8'h00, 4'hF, 32'h0,   32'h1, 3'b000, 4'd3},   // R3 again
    '{1'b0, 8'hFC, 4'hF, 32'h0,   32'h0, 3'b000, 4'd4},   // R4 top of window
    '{1'b0, 8'h01, 4'hF, 32'h0,   32'h0, 3'b000, 4'd4},   // R4 unaligned
    '{1'b1, 8'h05, 4'hF, 32'h1,   32'h0, 3'b000, 4'd10},  // R10 unaligned write, rdata holds (R13)
    '{1'b0, 8'h00, 4'h0, 32'h0,   32'h1, 3'b000, 4'd3}    // R3 strobes ignored on read
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        req_reset;
  logic        req_halt;
  logic        req_panic;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_ctl_regs u_pwr_ctl_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .req_reset (req_reset),
    .req_halt  (req_halt),
    .req_panic (req_panic)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
  endtask

  task automatic drive(input logic we, input logic [7:0] a, input logic [3:0] be,
                       input logic [31:0] wd);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
  endtask

  function automatic logic [31:0] pulses();
    return {29'd0, req_panic, req_halt, req_reset};
  endfunction

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 requests after reset", pulses(), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: access, check ready now, outputs next cycle, pulses clear after.
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].we, VECS[i].addr, VECS[i].be, VECS[i].wd);
      #1;
      check($sformatf("R2 ready vec %0d", i), {31'd0, bus_ready}, 32'h1);
      @(negedge clk);
      idle();
      #1;
      check($sformatf("R2 ready idle vec %0d", i), {31'd0, bus_ready}, 32'h0);
      check($sformatf("R%0d rdata vec %0d", VECS[i].req, i), bus_rdata, VECS[i].exp_rd);
      check($sformatf("R%0d pulses vec %0d", VECS[i].req, i), pulses(), {29'd0, VECS[i].exp_p});
      @(negedge clk);
      check($sformatf("R12 pulse width vec %0d", i), pulses(), 32'h0);
      check($sformatf("R13 rdata hold vec %0d", i), bus_rdata, VECS[i].exp_rd);
    end

    // R12: back-to-back commands give back-to-back single pulses.
    drive(1'b1, 8'h04, 4'hF, 32'h1);
    @(negedge clk);
    drive(1'b1, 8'h04, 4'hF, 32'h3);
    check("R12 first of pair", pulses(), 32'h1);
    @(negedge clk);
    idle();
    check("R12 second of pair", pulses(), 32'h4);
    @(negedge clk);
    check("R12 pair ends", pulses(), 32'h0);

    // R4: address beyond window offset on a wider bus is not possible at 8 bits;
    // read of 0x80 inside the window returns zero.
    drive(1'b0, 8'h80, 4'hF, 32'h0);
    @(negedge clk);
    idle();
    check("R4 read 0x80", bus_rdata, 32'h0);

    // R1: reset edge wins over a command write and clears rdata.
    drive(1'b0, 8'h00, 4'hF, 32'h0);
    @(negedge clk);
    check("R3 rdata before reset", bus_rdata, 32'h1);
    drive(1'b1, 8'h04, 4'hF, 32'h2);
    rst_n = 1'b0;
    @(negedge clk);
    idle();
    check("R1 write during reset", pulses(), 32'h0);
    check("R1 rdata cleared", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no late pulse", pulses(), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule